// File: doc/BRIEF.md
# Performance Level Sequencer for Voltage and Frequency Scaling

This block sets the voltage and clock speed of one CPU power domain. Software writes a wanted performance as a percentage. The block turns that into the closest of four operating levels. Each level has a supply voltage code, sent to an external regulator, and a clock divider select code, sent to the clock generator. The clock generator's PLL stays locked, so changing the select code does not stop execution. A hardware full-speed request input overrides the software level while it is high. When it drops, the domain goes back to whatever software wrote last.

The block moves between levels one step at a time and keeps the clock within what the supply can carry:
- **Speeding up:** it raises the voltage first, waits for the regulator to say the new voltage is stable, and only then speeds up the clock.
- **Slowing down:** it slows the clock first and then lowers the voltage.

The reported current level changes only when the regulator acknowledges a stable voltage point. As a result, the reported level follows the real supply, not the request. One interrupt pulse marks arrival at the target. Another marks a regulator that failed to acknowledge in time.

Top module: `dvs_level_ctrl`

## Requirements
- R1: After reset the block reports:
  - `cur_idx` = 0
  - `v_code` = 180
  - `clk_sel` = 0
  - `v_req` low, and both interrupt outputs low.
- R2: A write of percentage p selects the level whose nominal value is closest to p. The nominal values are:
  - index 0 = 100%
  - index 1 = 83%
  - index 2 = 66%
  - index 3 = 50%

  An exact tie picks the faster level (the lower index). Any p above 100 picks index 0.
- R3: Each level has fixed codes:
  - Voltage code for level i: 100 + floor(80*(3-i)/3), which gives 180, 153, 126 and 100.
  - Clock select code for level i: i (0 is full speed).
- R4: `cur_idx` moves by exactly one level per step. It changes only on the cycle after `v_ack` is seen while `v_req` is high. Each step consumes exactly one acknowledge.
- R5: On a step to a faster level, the new voltage code is requested while `clk_sel` still holds the old level's code. `clk_sel` takes the faster code on the same edge that `cur_idx` does.
- R6: On a step to a slower level, `clk_sel` takes the slower code one cycle before `v_req` rises with the lower voltage code.
- R7: While `max_perf` is high, the domain is driven to level 0. Target writes made during that time are stored but not acted on.
- R8: When `max_perf` falls, the domain heads to the level of the last software write.
- R9: A target write during a step does not change that step. The step completes, and the block then heads to the latest target.
- R10: `irq_done` pulses for one cycle when a completed step makes `cur_idx` equal to the effective target.
- R11: Suppose `v_ack` does not arrive within `TMO_CYC` cycles of `v_req` rising. Then:
  - `irq_tmo` pulses.
  - `v_req` drops.
  - `v_code` and `clk_sel` return to the codes of `cur_idx`, and `cur_idx` is unchanged.
  - The step is then retried.
- R12: A `v_ack` pulse while `v_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tgt_wr | input | 1 | Write strobe for the performance target |
| tgt_pct | input | 7 | Requested performance in percent |
| max_perf | input | 1 | Hardware request for full performance |
| v_ack | input | 1 | Regulator reports that the requested voltage is stable |
| v_req | output | 1 | Voltage request outstanding |
| v_code | output | 8 | Requested supply voltage code |
| clk_sel | output | 2 | Clock divider select code |
| cur_idx | output | 2 | Level whose voltage has been confirmed |
| irq_done | output | 1 | One-cycle pulse when the target level is reached |
| irq_tmo | output | 1 | One-cycle pulse when the regulator acknowledge times out |

## Verification
Every percentage from 0 to 127 is written in increasing order, each from the previous settled level:
- The written value checks where the tie and clamp points fall.
- The number of acknowledges consumed separates single-step moves from jumps.

Override sequences check that `max_perf` wins and that the block hands back to the stored target, including a target written during the override. A write made mid-step in the opposite direction shows whether the step is held. Silencing the regulator, once on a rising step and once on a falling step, shows the timeout restore for both orderings. A stray acknowledge shows that it is ignored. Throughout, a monitor compares `clk_sel` with the last acknowledged voltage to catch any clock-before-voltage ordering error.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  localparam int NLVL  = 4;
  localparam int IDX_W = $clog2(NLVL);
  localparam int PCT_W = 7;
  localparam int VC_W  = 8;
  localparam int V_HI  = 180;
  localparam int V_LO  = 100;

  typedef logic [IDX_W-1:0] lvl_t;
  typedef logic [VC_W-1:0]  vcode_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOWER_V, ST_WAIT_V} seq_st_t;

  // nominal performance of each level, percent of maximum
  function automatic int lvl_pct(input int i);
    case (i)
      0:       return 100;
      1:       return 83;
      2:       return 66;
      default: return 50;
    endcase
  endfunction

  // supply code spread evenly from V_HI (fastest) down to V_LO (slowest)
  function automatic vcode_t lvl_vcode(input lvl_t i);
    return vcode_t'(V_LO + ((V_HI - V_LO) * (NLVL - 1 - int'(i))) / (NLVL - 1));
  endfunction

  // clock divider select: the level number itself
  function automatic lvl_t lvl_clk(input lvl_t i);
    return i;
  endfunction
endpackage

// File: rtl/dvs_quantizer.sv
module dvs_quantizer
  import dvs_pkg::*;
(
  input  logic [PCT_W-1:0] pct,
  output lvl_t             idx
);
  localparam int NTHR = NLVL - 1;
  logic [NTHR-1:0] below;

  // midpoint thresholds, rounded up so a tie lands on the faster level
  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    localparam int THR = (lvl_pct(g) + lvl_pct(g + 1) + 1) / 2;
    assign below[g] = (pct < PCT_W'(THR));
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NTHR; k++) idx = lvl_t'(idx + lvl_t'(below[k]));
  end
endmodule

// File: rtl/dvs_target_sel.sv
module dvs_target_sel
  import dvs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  lvl_t wr_idx,
  input  logic force_max,
  output lvl_t eff_idx
);
  lvl_t sw_q, sw_d;

  always_comb sw_d = wr_en ? wr_idx : sw_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_d;

  assign eff_idx = force_max ? lvl_t'(0) : sw_q;
endmodule

// File: rtl/dvs_step_seq.sv
module dvs_step_seq
  import dvs_pkg::*;
#(
  parameter int TMO_CYC = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  lvl_t   eff_idx,
  input  logic   v_ack,
  output vcode_t v_code,
  output logic   v_req,
  output lvl_t   clk_sel,
  output lvl_t   cur_idx,
  output logic   irq_done,
  output logic   irq_tmo
);
  localparam int CW = $clog2(TMO_CYC + 1);

  seq_st_t        st_q, st_d;
  lvl_t           cur_q, cur_d, step_q, step_d, clk_q, clk_d;
  vcode_t         vc_q, vc_d;
  logic           req_q, req_d, done_q, done_d, tmo_q, tmo_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;   cur_d = cur_q; step_d = step_q; clk_d = clk_q;
    vc_d   = vc_q;   req_d = req_q; cnt_d  = cnt_q;
    done_d = 1'b0;   tmo_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (eff_idx < cur_q) begin            // faster: voltage first
          step_d = lvl_t'(cur_q - 1'b1);
          vc_d   = lvl_vcode(step_d);
          req_d  = 1'b1;
          cnt_d  = '0;
          st_d   = ST_WAIT_V;
        end else if (eff_idx > cur_q) begin   // slower: clock first
          step_d = lvl_t'(cur_q + 1'b1);
          clk_d  = lvl_clk(step_d);
          st_d   = ST_LOWER_V;
        end
      end
      ST_LOWER_V: begin
        vc_d  = lvl_vcode(step_q);
        req_d = 1'b1;
        cnt_d = '0;
        st_d  = ST_WAIT_V;
      end
      default: begin
        if (v_ack) begin
          cur_d  = step_q;
          clk_d  = lvl_clk(step_q);
          req_d  = 1'b0;
          done_d = (step_q == eff_idx);
          st_d   = ST_IDLE;
        end else if (cnt_q == CW'(TMO_CYC - 1)) begin
          vc_d  = lvl_vcode(cur_q);
          clk_d = lvl_clk(cur_q);
          req_d = 1'b0;
          tmo_d = 1'b1;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = CW'(cnt_q + 1'b1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= ST_IDLE;      cur_q <= '0;  step_q <= '0;
      clk_q  <= lvl_clk('0);  vc_q  <= lvl_vcode('0);
      req_q  <= 1'b0;         cnt_q <= '0;
      done_q <= 1'b0;         tmo_q <= 1'b0;
    end else begin
      st_q   <= st_d;   cur_q <= cur_d;  step_q <= step_d;
      clk_q  <= clk_d;  vc_q  <= vc_d;
      req_q  <= req_d;  cnt_q <= cnt_d;
      done_q <= done_d; tmo_q <= tmo_d;
    end

  assign v_code   = vc_q;
  assign v_req    = req_q;
  assign clk_sel  = clk_q;
  assign cur_idx  = cur_q;
  assign irq_done = done_q;
  assign irq_tmo  = tmo_q;
endmodule

// File: rtl/dvs_level_ctrl.sv
module dvs_level_ctrl
  import dvs_pkg::*;
#(
  parameter int TMO_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tgt_wr,
  input  logic [PCT_W-1:0] tgt_pct,
  input  logic             max_perf,
  input  logic             v_ack,
  output logic             v_req,
  output logic [VC_W-1:0]  v_code,
  output logic [IDX_W-1:0] clk_sel,
  output logic [IDX_W-1:0] cur_idx,
  output logic             irq_done,
  output logic             irq_tmo
);
  logic [1:0] rsync_q;
  logic       rst_in_n;
  lvl_t       wr_idx, eff_idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  assign rst_in_n = rsync_q[1];

  dvs_quantizer u_quant (.pct(tgt_pct), .idx(wr_idx));

  dvs_target_sel u_tsel (
    .clk(clk), .rst_n(rst_in_n), .wr_en(tgt_wr), .wr_idx(wr_idx),
    .force_max(max_perf), .eff_idx(eff_idx)
  );

  dvs_step_seq #(.TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_in_n), .eff_idx(eff_idx), .v_ack(v_ack),
    .v_code(v_code), .v_req(v_req), .clk_sel(clk_sel), .cur_idx(cur_idx),
    .irq_done(irq_done), .irq_tmo(irq_tmo)
  );
endmodule

// File: rtl/dvs_level_ctrl_chk.sv
module dvs_level_ctrl_chk
  import dvs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             max_perf,
  input logic             v_ack,
  input logic             v_req,
  input logic [VC_W-1:0]  v_code,
  input logic [IDX_W-1:0] clk_sel,
  input logic [IDX_W-1:0] cur_idx,
  input logic             irq_done,
  input logic             irq_tmo
);
  // R4: level moves only after an acknowledged request
  a_r4_move_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx != $past(cur_idx)) |-> $past(v_req && v_ack));

  // R4: one level per step
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx != $past(cur_idx)) |->
      ((cur_idx == lvl_t'($past(cur_idx) + 1'b1)) || (lvl_t'(cur_idx + 1'b1) == $past(cur_idx))));

  // R5: clock speeds up only on an acknowledge or a timeout restore
  a_r5_clk_up_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel < $past(clk_sel)) |-> ($past(v_req && v_ack) || irq_tmo));

  // R4: an accepted acknowledge closes the request
  a_r4_ack_closes_req: assert property (@(posedge clk) disable iff (!rst_n)
    (v_req && v_ack) |=> !v_req);

  // R7: under override, arrival is always at level 0
  a_r7_override_full: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && $past(max_perf)) |-> (cur_idx == '0));

  // R11: timeout drops the request and restores the current level's voltage
  a_r11_tmo_restore: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tmo |-> (!v_req && (v_code == lvl_vcode(cur_idx)) && (clk_sel == lvl_clk(cur_idx))));

  // R10: the two interrupts never coincide
  a_r10_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_tmo));
endmodule

bind dvs_level_ctrl dvs_level_ctrl_chk u_chk (.*);

// File: tb/dvs_level_ctrl_bench.sv
module dvs_level_ctrl_bench;
  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tgt_wr = 1'b0;
  logic [6:0] tgt_pct = '0;
  logic       max_perf = 1'b0;
  logic       reg_ack = 1'b0, man_ack = 1'b0;
  logic       v_ack;
  logic       v_req, irq_done, irq_tmo;
  logic [7:0] v_code;
  logic [1:0] clk_sel, cur_idx;

  assign v_ack = reg_ack | man_ack;

  dvs_level_ctrl #(.TMO_CYC(TMO)) u_dvs_level_ctrl (
    .clk(clk), .rst_n(rst_n), .tgt_wr(tgt_wr), .tgt_pct(tgt_pct),
    .max_perf(max_perf), .v_ack(v_ack), .v_req(v_req), .v_code(v_code),
    .clk_sel(clk_sel), .cur_idx(cur_idx), .irq_done(irq_done), .irq_tmo(irq_tmo)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int acks = 0, dones = 0, tmos = 0, cyc = 0;
  bit ack_en = 1'b1;
  int settled = 0;

  function automatic int exp_vcode(input int i);
    return 100 + (80 * (3 - i)) / 3;
  endfunction

  function automatic int idx_of(input int vc);
    for (int i = 0; i < 4; i++) if (exp_vcode(i) == vc) return i;
    return -1;
  endfunction

  function automatic int nominal(input int i);
    case (i) 0: return 100; 1: return 83; 2: return 66; default: return 50; endcase
  endfunction

  function automatic int closest(input int p);
    int best = 0, bd = 1000, d;
    for (int i = 0; i < 4; i++) begin
      d = (p > nominal(i)) ? p - nominal(i) : nominal(i) - p;
      if (d < bd) begin bd = d; best = i; end
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // regulator model, monitors and watchdog
  initial begin
    int wcnt = 0, pend = 0, ni;
    bit prev_req = 1'b0;
    int prev_clk = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        finish_run();
      end
      if (reg_ack) begin settled = pend; acks++; end
      if (irq_done) dones++;
      if (irq_tmo)  tmos++;
      if (int'(clk_sel) != prev_clk) begin
        check(int'(clk_sel) >= settled, "R5 clock faster than settled voltage", clk_sel, settled);
        prev_clk = clk_sel;
      end
      if (v_req && !prev_req) begin
        ni = idx_of(v_code);
        if (ni < settled)      check(int'(clk_sel) == settled, "R5 clock held until voltage up", clk_sel, settled);
        else if (ni > settled) check(int'(clk_sel) == ni, "R6 clock lowered before voltage", clk_sel, ni);
      end
      prev_req = v_req;
      reg_ack = 1'b0;
      if (v_req && ack_en && rst_n) begin
        if (wcnt == 2) begin reg_ack = 1'b1; pend = idx_of(v_code); wcnt = 0; end
        else wcnt++;
      end else wcnt = 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic write_pct(input int p);
    tgt_pct = 7'(p); tgt_wr = 1'b1;
    tick(1);
    tgt_wr = 1'b0;
  endtask

  task automatic settle(input int expv, input string tag);
    int n = 0;
    while (!(int'(cur_idx) == expv && !v_req) && n < 300) begin tick(1); n++; end
    tick(2);
    check(int'(cur_idx) == expv, tag, cur_idx, expv);
    check(int'(v_code) == exp_vcode(expv), "R3 voltage code of level", v_code, exp_vcode(expv));
    check(int'(clk_sel) == expv, "R3 clock select of level", clk_sel, expv);
  endtask

  initial begin
    int a0, d0, t0, e, prev;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    check(cur_idx == 2'd0, "R1 cur_idx", cur_idx, 0);
    check(v_code == 8'd180, "R1 v_code", v_code, 180);
    check(clk_sel == 2'd0, "R1 clk_sel", clk_sel, 0);
    check(!v_req && !irq_done && !irq_tmo, "R1 req and irqs low", {v_req, irq_done, irq_tmo}, 0);

    // R2 sweep of every percentage; R4 step count, R10 one arrival pulse
    prev = 0;
    for (int p = 0; p < 128; p++) begin
      a0 = acks; d0 = dones;
      e = closest(p);
      write_pct(p);
      settle(e, "R2 quantized level");
      check(acks - a0 == ((e > prev) ? e - prev : prev - e), "R4 acks per move", acks - a0,
            (e > prev) ? e - prev : prev - e);
      check(dones - d0 == ((e != prev) ? 1 : 0), "R10 arrival pulses", dones - d0, (e != prev) ? 1 : 0);
      prev = e;
    end

    // R7 override and R8 hand-back
    write_pct(50); settle(3, "R2 level 50%");
    a0 = acks; d0 = dones;
    max_perf = 1'b1;
    settle(0, "R7 override to full");
    check(acks - a0 == 3, "R7 override steps", acks - a0, 3);
    check(dones - d0 == 1, "R10 override arrival", dones - d0, 1);
    write_pct(66);
    tick(20);
    check(cur_idx == 2'd0 && !v_req, "R7 write during override not acted", cur_idx, 0);
    a0 = acks;
    max_perf = 1'b0;
    settle(2, "R8 back to last write");
    check(acks - a0 == 2, "R8 steps on hand-back", acks - a0, 2);

    // R9 write during a step is held
    write_pct(50); settle(3, "R2 level 50% again");
    a0 = acks; d0 = dones;
    write_pct(100);
    while (!v_req) tick(1);
    write_pct(50);
    check(int'(v_code) == exp_vcode(2), "R9 step unchanged by write", v_code, exp_vcode(2));
    settle(3, "R9 returns to latest target");
    check(acks - a0 == 2, "R9 step completed then reversed", acks - a0, 2);
    check(dones - d0 == 1, "R10 only final arrival", dones - d0, 1);

    // R12 stray acknowledge
    d0 = dones; t0 = tmos;
    man_ack = 1'b1; tick(1); man_ack = 1'b0;
    tick(3);
    check(cur_idx == 2'd3 && !v_req, "R12 stray ack ignored", cur_idx, 3);
    check(dones == d0 && tmos == t0, "R12 no interrupt from stray ack", dones - d0, 0);

    // R11 timeout on a rising step, then retry
    ack_en = 1'b0;
    write_pct(100);
    begin int n = 0; while (!irq_tmo && n < 100) begin tick(1); n++; end end
    check(irq_tmo == 1'b1, "R11 timeout pulse rising", irq_tmo, 1);
    check(!v_req && cur_idx == 2'd3, "R11 request dropped, level kept", cur_idx, 3);
    check(int'(v_code) == exp_vcode(3) && clk_sel == 2'd3, "R11 codes restored rising", v_code, exp_vcode(3));
    t0 = tmos;
    tick(3 * TMO);
    check(tmos > t0, "R11 step retried", tmos - t0, 1);
    ack_en = 1'b1;
    settle(0, "R11 completes after regulator recovers");

    // R11 timeout on a falling step
    ack_en = 1'b0;
    write_pct(50);
    begin int n = 0; while (!irq_tmo && n < 100) begin tick(1); n++; end end
    check(irq_tmo == 1'b1, "R11 timeout pulse falling", irq_tmo, 1);
    check(clk_sel == 2'd0 && int'(v_code) == exp_vcode(0), "R11 codes restored falling", clk_sel, 0);
    check(cur_idx == 2'd0, "R11 level kept falling", cur_idx, 0);
    ack_en = 1'b1;
    settle(3, "R11 falling completes");

    finish_run();
  end
endmodule